// File: doc/BRIEF.md
# Nibble-Serial Host Handshake Port

This block is the device side of a four-bit host port that moves whole packets between a host controller and a local packet buffer. Each byte crosses the port as two nibbles, the low nibble first. Every nibble is paced by a fully interlocked four-phase handshake on two line pairs, all active low. In one pair the host requests a download and the device accepts it. In the other pair the device requests an upload and the host accepts it. Because the handshake is interlocked, the host may stall between any two steps for as long as it likes, up to a watchdog limit.

When the host releases its download request and leaves it released for a set number of cycles after a complete byte, the packet is closed. Its first byte is a control byte, and its class decides what happens next. A data packet is announced to the local logic with its byte count. A configuration write produces a one-cycle write strobe towards an external configuration store. A configuration read turns the port around, and the device uploads two bytes: an echo of the control byte, then the addressed contents. Local logic can also fill the buffer and launch an upload of its own. The device drives the data bus only while an upload is in progress. If the host stops answering for too long, the transfer is abandoned and the port returns to idle.

Top module: `nibble_port`

## Requirements
- R1: After reset, txack_n and rxreq_n are high, bus_oe is low, and dl_done and mem_we are low.
- R2: When the host drives txreq_n low, the device drives txack_n low. When txreq_n returns high, the device captures bus_in and drives txack_n high. The first nibble of each byte is bits 3:0 and the second is bits 7:4.
- R3: After a complete byte, if txreq_n stays high for END_GAP cycles, the packet closes. If bit 7 of byte 0 is 0, dl_done pulses for one cycle with dl_len equal to the number of stored bytes. Byte k can then be read on side_rdata at side_addr = k.
- R4: At most MAX_BYTES (28) bytes are stored. Later bytes are still handshaken but discarded, and dl_len saturates at MAX_BYTES.
- R5: A pulse on up_go in idle, with up_len nonzero, uploads buffer bytes 0 to up_len-1. For each nibble the device drives bus_oe high, presents the nibble (low nibble first) and drives rxreq_n low. When rxack_n goes low, the device drives rxreq_n high while holding the nibble. When rxack_n returns high, the device moves to the next nibble.
- R6: After the last nibble of an upload is accepted, bus_oe goes low and rxreq_n stays high. bus_oe is never high while txack_n is low.
- R7: A closed packet whose byte 0 has bit 7 = 1 and bit 6 = 1 is a configuration write with address bits 5:0. If the packet holds at least two bytes, mem_we pulses once with mem_addr set to that address and mem_wdata set to byte 1. No dl_done follows.
- R8: A closed packet whose byte 0 has bit 7 = 1 and bit 6 = 0 is a configuration read. The device uploads two bytes: byte 0 as an echo, then mem_rdata sampled at mem_addr = byte0[5:0]. No dl_done follows.
- R9: If the port is busy with a transfer and sees no edge on txreq_n or rxack_n for TMO_CYCLES cycles, the transfer is abandoned. txack_n and rxreq_n go high, bus_oe goes low, no dl_done is raised for the partial packet, and the next download starts again at byte 0.
- R10: up_go and side_we are ignored while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txreq_n | input | 1 | Host download request, active low |
| txack_n | output | 1 | Device download accept, active low |
| rxreq_n | output | 1 | Device upload request, active low |
| rxack_n | input | 1 | Host upload accept, active low |
| bus_in | input | 4 | Nibble from the host |
| bus_out | output | 4 | Nibble to the host |
| bus_oe | output | 1 | Device drives the nibble bus |
| dl_done | output | 1 | One-cycle pulse: data packet closed |
| dl_len | output | LEN_W | Byte count of the last closed data packet |
| up_go | input | 1 | Start an upload from the buffer |
| up_len | input | LEN_W | Number of bytes to upload |
| side_we | input | 1 | Local buffer write strobe |
| side_addr | input | IDX_W | Local buffer address |
| side_wdata | input | 8 | Local buffer write data |
| side_rdata | output | 8 | Local buffer read data |
| mem_addr | output | 6 | Configuration address from the control byte |
| mem_we | output | 1 | Configuration write strobe |
| mem_wdata | output | 8 | Configuration write data |
| mem_rdata | input | 8 | Configuration read data at mem_addr |

## Verification
The hardest case to reach from the ports is a watchdog expiry in the middle of a nibble, where the host has seen its request accepted but never completes the phase. A close second is the turnaround after a configuration read, where the device must start driving the bus without any prompt from the host. The bench builds the port with a short watchdog limit and plays the host. To reach an expiry, it stalls on purpose at a chosen phase, either holding its download request low or never accepting an upload nibble. It then confirms that a fresh packet afterwards is counted from zero. For the read turnaround, it sends a single read control byte and simply waits for the upload request, then collects the echo and the data byte.

// File: rtl/nhp_pkg.sv
package nhp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DL_ACK,
      ST_DL_GAP,
      ST_UL_PRES,
      ST_UL_HOLD
   } port_state_t;

   localparam int unsigned CTRL_CLASS_BIT = 7;
   localparam int unsigned CTRL_WRITE_BIT = 6;
   localparam int unsigned CFG_AW         = 6;
endpackage

// File: rtl/nhp_sync.sv
module nhp_sync #(
   parameter int               WIDTH   = 2,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("nhp_sync needs at least two stages");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/nhp_watchdog.sv
module nhp_watchdog #(
   parameter int unsigned LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic kick,
   output logic expire
);
   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt <= '0;
      else if (!run || kick)             cnt <= '0;
      else if (cnt != CW'(LIMIT - 1))    cnt <= cnt + 1'b1;
   end

   assign expire = run && !kick && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/nhp_buffer.sv
module nhp_buffer #(
   parameter int DEPTH     = 28,
   parameter int AW        = 5,
   parameter bit CLEAR_RST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [7:0]    rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [7:0]    rdata_b,
   output logic [7:0]    head0,
   output logic [7:0]    head1
);
   logic [7:0] mem [DEPTH];

   if (CLEAR_RST) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (we && int'(waddr) < DEPTH) begin
            mem[waddr] <= wdata;
         end
      end
   end else begin : g_noclr
      always_ff @(posedge clk) begin
         if (we && int'(waddr) < DEPTH) mem[waddr] <= wdata;
      end
   end

   assign rdata_a = (int'(raddr_a) < DEPTH) ? mem[raddr_a] : 8'h00;
   assign rdata_b = (int'(raddr_b) < DEPTH) ? mem[raddr_b] : 8'h00;
   assign head0   = mem[0];
   assign head1   = mem[1];
endmodule

// File: rtl/nibble_port.sv
module nibble_port
   import nhp_pkg::*;
#(
   parameter int          MAX_BYTES  = 28,
   parameter int unsigned TMO_CYCLES = 145_000_000,
   parameter int unsigned END_GAP    = 50_000,
   parameter int          SYNC_STG   = 2,
   parameter bit          CLEAR_RST  = 1'b1,
   localparam int         IDX_W      = $clog2(MAX_BYTES),
   localparam int         LEN_W      = $clog2(MAX_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             txreq_n,
   output logic             txack_n,
   output logic             rxreq_n,
   input  logic             rxack_n,
   input  logic [3:0]       bus_in,
   output logic [3:0]       bus_out,
   output logic             bus_oe,
   output logic             dl_done,
   output logic [LEN_W-1:0] dl_len,
   input  logic             up_go,
   input  logic [LEN_W-1:0] up_len,
   input  logic             side_we,
   input  logic [IDX_W-1:0] side_addr,
   input  logic [7:0]       side_wdata,
   output logic [7:0]       side_rdata,
   output logic [5:0]       mem_addr,
   output logic             mem_we,
   output logic [7:0]       mem_wdata,
   input  logic [7:0]       mem_rdata
);
   localparam int GW = $clog2(END_GAP + 1);
   localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_BYTES);

   if (MAX_BYTES < 2 || MAX_BYTES > 64) begin : g_bad_depth
      $error("MAX_BYTES must lie in 2..64");
   end
   if (END_GAP < 2 || END_GAP >= TMO_CYCLES) begin : g_bad_gap
      $error("END_GAP must be at least 2 and below TMO_CYCLES");
   end

   // handshake inputs: [1] download request, [0] upload accept
   logic [1:0] hs_s, hs_d;
   logic [3:0] bus_q;
   nhp_sync #(.WIDTH(2), .STAGES(SYNC_STG), .RST_VAL(2'b11)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({txreq_n, rxack_n}), .q(hs_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin hs_d <= 2'b11; bus_q <= '0; end
      else        begin hs_d <= hs_s;  bus_q <= bus_in; end
   end

   wire treq_fall = hs_d[1] & ~hs_s[1];
   wire treq_rise = ~hs_d[1] & hs_s[1];
   wire rack_fall = hs_d[0] & ~hs_s[0];
   wire rack_rise = ~hs_d[0] & hs_s[0];

   port_state_t      state;
   logic             nib;
   logic [3:0]       lo_nib;
   logic [LEN_W-1:0] cnt, idx, ulen;
   logic [GW-1:0]    gap;
   logic             wd_expire;
   logic [7:0]       head0, head1, up_byte;
   logic             b_we;
   logic [IDX_W-1:0] b_waddr;
   logic [7:0]       b_wdata;

   nhp_watchdog #(.LIMIT(TMO_CYCLES)) u_wdog (
      .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE),
      .kick(treq_fall | treq_rise | rack_fall | rack_rise), .expire(wd_expire));

   nhp_buffer #(.DEPTH(MAX_BYTES), .AW(IDX_W), .CLEAR_RST(CLEAR_RST)) u_buf (
      .clk(clk), .rst_n(rst_n), .we(b_we), .waddr(b_waddr), .wdata(b_wdata),
      .raddr_a(side_addr), .rdata_a(side_rdata),
      .raddr_b(idx[IDX_W-1:0]), .rdata_b(up_byte),
      .head0(head0), .head1(head1));

   wire gap_end   = (state == ST_DL_GAP) && !nib && !treq_fall && (gap == GW'(END_GAP - 1));
   wire is_cfg    = head0[CTRL_CLASS_BIT];
   wire is_cfg_wr = head0[CTRL_WRITE_BIT];

   always_comb begin
      b_we    = 1'b0;
      b_waddr = side_addr;
      b_wdata = side_wdata;
      unique case (state)
         ST_IDLE:   b_we = side_we;
         ST_DL_ACK: if (treq_rise && nib && cnt < MAX_L) begin
                       b_we    = 1'b1;
                       b_waddr = cnt[IDX_W-1:0];
                       b_wdata = {bus_q, lo_nib};
                    end
         ST_DL_GAP: if (gap_end && is_cfg && !is_cfg_wr) begin
                       b_we    = 1'b1;
                       b_waddr = IDX_W'(1);
                       b_wdata = mem_rdata;
                    end
         default:   b_we = 1'b0;
      endcase
      if (wd_expire) b_we = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;  nib <= 1'b0;  lo_nib <= '0;
         cnt <= '0;  idx <= '0;  ulen <= '0;  gap <= '0;
         txack_n <= 1'b1;  rxreq_n <= 1'b1;  bus_oe <= 1'b0;
         dl_done <= 1'b0;  dl_len <= '0;  mem_we <= 1'b0;  mem_wdata <= '0;
      end else begin
         dl_done <= 1'b0;
         mem_we  <= 1'b0;
         if (wd_expire) begin
            state <= ST_IDLE;  txack_n <= 1'b1;  rxreq_n <= 1'b1;
            bus_oe <= 1'b0;  cnt <= '0;  nib <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: begin
                  if (treq_fall) begin
                     state <= ST_DL_ACK;  txack_n <= 1'b0;  cnt <= '0;  nib <= 1'b0;
                  end else if (up_go && up_len != '0) begin
                     state <= ST_UL_PRES;  ulen <= (up_len > MAX_L) ? MAX_L : up_len;
                     idx <= '0;  nib <= 1'b0;  bus_oe <= 1'b1;  rxreq_n <= 1'b0;
                  end
               end
               ST_DL_ACK: if (treq_rise) begin
                  txack_n <= 1'b1;  nib <= ~nib;  gap <= '0;  state <= ST_DL_GAP;
                  if (!nib)              lo_nib <= bus_q;
                  else if (cnt < MAX_L)  cnt <= cnt + 1'b1;
               end
               ST_DL_GAP: begin
                  if (treq_fall) begin
                     txack_n <= 1'b0;  state <= ST_DL_ACK;
                  end else if (gap_end) begin
                     state <= ST_IDLE;
                     if (!is_cfg) begin
                        dl_done <= 1'b1;  dl_len <= cnt;
                     end else if (is_cfg_wr) begin
                        mem_we    <= (cnt >= LEN_W'(2));
                        mem_wdata <= head1;
                     end else begin
                        state <= ST_UL_PRES;  ulen <= LEN_W'(2);  idx <= '0;
                        nib <= 1'b0;  bus_oe <= 1'b1;  rxreq_n <= 1'b0;
                     end
                  end else if (!nib) begin
                     gap <= gap + 1'b1;
                  end
               end
               ST_UL_PRES: if (rack_fall) begin
                  rxreq_n <= 1'b1;  state <= ST_UL_HOLD;
               end
               ST_UL_HOLD: if (rack_rise) begin
                  if (nib && idx == ulen - 1'b1) begin
                     bus_oe <= 1'b0;  state <= ST_IDLE;
                  end else begin
                     if (nib) idx <= idx + 1'b1;
                     nib <= ~nib;  rxreq_n <= 1'b0;  state <= ST_UL_PRES;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign bus_out  = nib ? up_byte[7:4] : up_byte[3:0];
   assign mem_addr = head0[CFG_AW-1:0];
endmodule

// File: rtl/nibble_port_chk.sv
module nibble_port_chk #(
   parameter int MAX_BYTES = 28,
   parameter int LEN_W     = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             txack_n,
   input logic             rxreq_n,
   input logic [3:0]       bus_out,
   input logic             bus_oe,
   input logic             dl_done,
   input logic [LEN_W-1:0] dl_len,
   input logic             mem_we
);
   AST_NO_ACCEPT_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> txack_n);                                                      // R6
   AST_REQ_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !rxreq_n |-> bus_oe);                                                     // R5
   AST_NIBBLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rxreq_n && !$past(rxreq_n)) |-> $stable(bus_out));                      // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      dl_done |=> !dl_done);                                                    // R3
   AST_LEN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      dl_done |-> (dl_len != '0 && int'(dl_len) <= MAX_BYTES));                // R4
   AST_CFG_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);                                                      // R7
   AST_CFG_NOT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && dl_done));                                                    // R7
endmodule

bind nibble_port nibble_port_chk #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .txack_n(txack_n), .rxreq_n(rxreq_n),
   .bus_out(bus_out), .bus_oe(bus_oe), .dl_done(dl_done), .dl_len(dl_len),
   .mem_we(mem_we));

// File: tb/nibble_port_bench.sv
module nibble_port_bench;
   localparam int MAXB = 28;
   localparam int TMO  = 2000;
   localparam int GAP  = 150;
   localparam int IW   = 5;
   localparam int LW   = 5;

   // table: {byte count, seed}
   localparam logic [15:0] DL_TAB [6] = '{16'h01_11, 16'h03_22, 16'h07_35,
                                          16'h1B_4A, 16'h1C_03, 16'h1F_66};

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          txreq_n = 1'b1, rxack_n = 1'b1;
   logic [3:0]    bus_drv = '0;
   logic          txack_n, rxreq_n, bus_oe, dl_done, mem_we;
   logic [3:0]    bus_out;
   logic [LW-1:0] dl_len;
   logic          up_go = 1'b0;
   logic [LW-1:0] up_len = '0;
   logic          side_we = 1'b0;
   logic [IW-1:0] side_addr = '0;
   logic [7:0]    side_wdata = '0, side_rdata, mem_wdata, mem_rdata;
   logic [5:0]    mem_addr;

   assign mem_rdata = {2'b01, mem_addr} ^ 8'hA5;

   nibble_port #(.MAX_BYTES(MAXB), .TMO_CYCLES(TMO), .END_GAP(GAP)) u_nibble_port (
      .clk(clk), .rst_n(rst_n), .txreq_n(txreq_n), .txack_n(txack_n),
      .rxreq_n(rxreq_n), .rxack_n(rxack_n), .bus_in(bus_drv), .bus_out(bus_out),
      .bus_oe(bus_oe), .dl_done(dl_done), .dl_len(dl_len), .up_go(up_go),
      .up_len(up_len), .side_we(side_we), .side_addr(side_addr),
      .side_wdata(side_wdata), .side_rdata(side_rdata), .mem_addr(mem_addr),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

   int n_chk = 0, n_fail = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
      if (i == 0) return {1'b0, seed[6:0]};
      return 8'(int'(seed) + i * 37);
   endfunction

   task automatic wait_txack(input logic v, output bit ok);
      ok = 1'b0;
      for (int i = 0; i < TMO / 2; i++) begin
         if (txack_n == v) begin ok = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   task automatic wait_rxreq(input logic v, output bit ok);
      ok = 1'b0;
      for (int i = 0; i < TMO / 2; i++) begin
         if (rxreq_n == v) begin ok = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   task automatic send_nib(input logic [3:0] n);
      bit ok;
      @(negedge clk); txreq_n = 1'b0;
      wait_txack(1'b0, ok);
      if (!ok) check(1'b0, "R2 accept", int'(txack_n), 0);
      bus_drv = n;
      @(negedge clk); txreq_n = 1'b1;
      wait_txack(1'b1, ok);
      if (!ok) check(1'b0, "R2 release", int'(txack_n), 1);
   endtask

   task automatic send_byte(input logic [7:0] b);
      send_nib(b[3:0]);   // R2: low nibble first
      send_nib(b[7:4]);
   endtask

   task automatic recv_nib(output logic [3:0] n);
      bit ok;
      wait_rxreq(1'b0, ok);
      if (!ok) check(1'b0, "R5 request", int'(rxreq_n), 0);
      if (!bus_oe) check(1'b0, "R5 drive", int'(bus_oe), 1);
      n = bus_out;
      @(negedge clk); rxack_n = 1'b0;
      wait_rxreq(1'b1, ok);
      if (!ok) check(1'b0, "R5 release", int'(rxreq_n), 1);
      if (bus_out != n) check(1'b0, "R5 hold", int'(bus_out), int'(n));
      @(negedge clk); rxack_n = 1'b1;
   endtask

   task automatic recv_byte(output logic [7:0] b);
      logic [3:0] lo, hi;
      recv_nib(lo);
      recv_nib(hi);
      b = {hi, lo};
   endtask

   task automatic wait_done(output bit seen, output logic [LW-1:0] len, output bit cfg_we);
      seen = 1'b0; len = '0; cfg_we = 1'b0;
      for (int i = 0; i < GAP + 100; i++) begin
         @(negedge clk);
         if (mem_we) cfg_we = 1'b1;
         if (dl_done) begin seen = 1'b1; len = dl_len; end
      end
   endtask

   function automatic logic [7:0] buf_rd_dummy(input int a); return 8'(a); endfunction

   task automatic read_side(input int a, output logic [7:0] d);
      @(negedge clk); side_addr = IW'(a);
      #1 d = side_rdata;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      bit seen, cfgw;
      logic [LW-1:0] len;
      logic [7:0] d;
      repeat (4) @(negedge clk);
      // R1 reset state
      check(txack_n == 1'b1 && rxreq_n == 1'b1, "R1 handshake idle", {txack_n, rxreq_n}, 3);
      check(bus_oe == 1'b0 && dl_done == 1'b0 && mem_we == 1'b0, "R1 outputs low",
            {bus_oe, dl_done, mem_we}, 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // table-driven data packets: R2, R3, R4
      for (int e = 0; e < 6; e++) begin
         int nb, keep, bad;
         nb   = int'(DL_TAB[e][15:8]);
         keep = (nb > MAXB) ? MAXB : nb;
         for (int i = 0; i < nb; i++) send_byte(pat(DL_TAB[e][7:0], i));
         wait_done(seen, len, cfgw);
         check(seen, "R3 done pulse", int'(seen), 1);
         check(int'(len) == keep, (nb > MAXB) ? "R4 length cap" : "R3 length", int'(len), keep);
         bad = 0;
         for (int i = 0; i < keep; i++) begin
            read_side(i, d);
            if (d != pat(DL_TAB[e][7:0], i)) begin
               bad++;
               check(1'b0, "R2 R3 content", int'(d), int'(pat(DL_TAB[e][7:0], i)));
            end
         end
         check(bad == 0, (nb > MAXB) ? "R4 stored bytes" : "R3 stored bytes", bad, 0);
      end

      // R5 / R6: local upload
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); side_we = 1'b1; side_addr = IW'(i); side_wdata = 8'(8'h3C + i * 29);
      end
      @(negedge clk); side_we = 1'b0; up_len = LW'(5); up_go = 1'b1;
      @(negedge clk); up_go = 1'b0;
      begin
         int bad = 0;
         for (int i = 0; i < 5; i++) begin
            recv_byte(d);
            if (d != 8'(8'h3C + i * 29)) begin
               bad++;
               check(1'b0, "R5 upload byte", int'(d), int'(8'(8'h3C + i * 29)));
            end
         end
         check(bad == 0, "R5 upload sequence", bad, 0);
      end
      repeat (6) @(negedge clk);
      check(bus_oe == 1'b0 && rxreq_n == 1'b1, "R6 release after upload", {bus_oe, rxreq_n}, 1);

      // R7: configuration write
      send_byte(8'hD5);
      send_byte(8'hA7);
      begin
         bit got = 1'b0, dn = 1'b0;
         logic [5:0] wa = '0;
         logic [7:0] wd = '0;
         for (int i = 0; i < GAP + 100; i++) begin
            @(negedge clk);
            if (mem_we) begin got = 1'b1; wa = mem_addr; wd = mem_wdata; end
            if (dl_done) dn = 1'b1;
         end
         check(got, "R7 write strobe", int'(got), 1);
         check(wa == 6'h15 && wd == 8'hA7, "R7 address and data", {wa, wd}, {6'h15, 8'hA7});
         check(!dn, "R7 no data done", int'(dn), 0);
      end

      // R8: configuration read with echo
      send_byte(8'hAB);
      recv_byte(d);
      check(d == 8'hAB, "R8 echo", int'(d), 8'hAB);
      recv_byte(d);
      check(d == ({2'b01, 6'h2B} ^ 8'hA5), "R8 read data", int'(d), int'({2'b01, 6'h2B} ^ 8'hA5));
      repeat (6) @(negedge clk);
      check(bus_oe == 1'b0 && dl_done == 1'b0, "R8 turnaround done", {bus_oe, dl_done}, 0);

      // R9: host stalls during download
      begin
         bit ok;
         @(negedge clk); txreq_n = 1'b0;
         wait_txack(1'b0, ok);
         check(ok, "R9 accepted before stall", int'(txack_n), 0);
         repeat (TMO + 50) @(negedge clk);
         check(txack_n == 1'b1, "R9 download abandoned", int'(txack_n), 1);
         txreq_n = 1'b1;
         repeat (10) @(negedge clk);
         send_byte(8'h21);
         send_byte(8'h9E);
         wait_done(seen, len, cfgw);
         check(seen && len == LW'(2), "R9 fresh count", int'(len), 2);
      end

      // R9: host never accepts an upload nibble
      begin
         bit ok;
         @(negedge clk); up_len = LW'(3); up_go = 1'b1;
         @(negedge clk); up_go = 1'b0;
         wait_rxreq(1'b0, ok);
         check(ok && bus_oe, "R9 upload started", int'(bus_oe), 1);
         repeat (TMO + 50) @(negedge clk);
         check(bus_oe == 1'b0 && rxreq_n == 1'b1, "R9 upload abandoned", {bus_oe, rxreq_n}, 1);
      end

      // R10: local strobes ignored while busy
      begin
         bit quiet = 1'b1;
         send_byte(8'h12);
         @(negedge clk);
         up_go = 1'b1; up_len = LW'(4); side_we = 1'b1; side_addr = '0; side_wdata = 8'hEE;
         @(negedge clk); up_go = 1'b0; side_we = 1'b0;
         send_byte(8'h34);
         send_byte(8'h56);
         wait_done(seen, len, cfgw);
         check(seen && len == LW'(3), "R10 packet intact", int'(len), 3);
         read_side(0, d);
         check(d == 8'h12, "R10 side write ignored", int'(d), 8'h12);
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!rxreq_n || bus_oe) quiet = 1'b0;
         end
         check(quiet, "R10 upload start ignored", int'(quiet), 1);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule